// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits beside an Ethernet receive path and decides, for every incoming frame, whether the frame is kept or dropped, judged only by its destination MAC address. It watches a byte stream, gathers the first six bytes of each frame, sorts the destination into one of four classes (broadcast, multicast, exact station match, other unicast) and issues a one-cycle decision carrying an accept flag and the class code.

Software configures it through two 32-bit locations. The control location holds the mode flags together with a byte-offset pointer. The data location reaches the 16-bit station-address word that the pointer selects. The station address is written and read back one 16-bit word at a time. Changes to the address or to the accept flags only take effect while the master enable is clear. Writing the enable back to one brings the new settings into use.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, dec_valid and dec_accept are low, the control location reads 0x00000000, and every station-address word reads 0x0000.
- R2: Control location (cfg_sel=0) bit map: bit 31 master enable, bit 30 accept broadcast, bit 29 accept multicast, bit 28 accept any unicast, bit 27 accept exact station match, bits 2:0 byte-offset pointer. All other bits read as zero, and a read returns the stored flags and pointer.
- R3: With the pointer at byte offset 0, 2 or 4, a data write (cfg_sel=1) stores cfg_wdata[15:0] as that station word. The lower-numbered address byte is in bits 7:0 and the next byte is in bits 15:8. A data read returns the stored word. At any other offset, writes are ignored and reads return zero.
- R4: While the enable is set, data writes leave the station address unchanged, and control writes update only the enable and the pointer. The accept flags are taken from a control write only when the enable was clear before that write, including the write that sets it.
- R5: The decision (dec_valid high for one cycle) appears in the cycle after the sixth valid byte of a frame. Later bytes of the same frame produce no further decision. A frame's first byte is the first valid byte after reset or after a byte marked rx_last.
- R6: Class code: 2'b11 when all 48 destination bits are one, 2'b10 when bit 0 of the first byte is set and the address is not broadcast, 2'b01 when the address equals the station address and is neither of those, and 2'b00 otherwise.
- R7: With the enable set, a frame is accepted when it is broadcast with the broadcast flag set, multicast with the multicast flag set, unicast with the unicast flag set, or equal to the station address with the match flag set.
- R8: With the enable clear, every decision has dec_accept low, but the class is still reported.
- R9: A frame that ends (rx_last) before its sixth byte produces, in the cycle after that last byte, a decision with dec_accept low and class 2'b00.
- R10: Cycles with rx_valid low do not advance the byte position and do not change the captured bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the control location, 1 selects the data location |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data of the selected location |
| rx_valid | input | 1 | Byte-stream qualifier |
| rx_data | input | 8 | Frame byte, first destination byte first |
| rx_last | input | 1 | Marks the final byte of a frame |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Keep the frame (qualified by dec_valid) |
| dec_class | output | 2 | Destination class (qualified by dec_valid) |

## Verification
The checks assume that rx_last is only meaningful together with rx_valid, and that frames are delimited purely by rx_last, so any byte stream is legal input. The configuration inputs are assumed to be driven only in whole-cycle pulses. The bench holds every input stable between falling clock edges and only changes the station address after clearing the enable, which is the software ordering the block expects. Some writes are deliberately made while the enable is set, so the properties that the settings stay frozen are exercised on real traffic.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int CFG_W = 32;

  typedef enum logic [1:0] {
    CLS_OTHER   = 2'b00,
    CLS_STATION = 2'b01,
    CLS_MCAST   = 2'b10,
    CLS_BCAST   = 2'b11
  } dst_class_e;

  // Packed order matches control bits 31..27.
  typedef struct packed {
    logic en;
    logic acc_bc;
    logic acc_mc;
    logic acc_uc;
    logic acc_pm;
  } filt_mode_t;

  localparam int MODE_LSB = CFG_W - 5;

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int MAC_BYTES = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic                   cfg_sel,
  input  logic [CFG_W-1:0]       cfg_wdata,
  output logic [CFG_W-1:0]       cfg_rdata,
  output filt_mode_t             mode,
  output logic [8*MAC_BYTES-1:0] station
);

  localparam int NWORDS = MAC_BYTES / 2;
  localparam int PTR_W  = $clog2(MAC_BYTES);
  localparam int ADDR_W = 8 * MAC_BYTES;

  filt_mode_t        mode_q, mode_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [ADDR_W-1:0] station_q, station_d;
  logic              ctrl_wr, data_wr;
  logic [15:0]       rd_word;

  assign ctrl_wr = cfg_wr && !cfg_sel;
  assign data_wr = cfg_wr && cfg_sel;

  always_comb begin
    mode_d = mode_q;
    ptr_d  = ptr_q;
    if (ctrl_wr) begin
      ptr_d     = cfg_wdata[PTR_W-1:0];
      mode_d.en = cfg_wdata[CFG_W-1];
      if (!mode_q.en) begin
        mode_d.acc_bc = cfg_wdata[CFG_W-2];
        mode_d.acc_mc = cfg_wdata[CFG_W-3];
        mode_d.acc_uc = cfg_wdata[CFG_W-4];
        mode_d.acc_pm = cfg_wdata[CFG_W-5];
      end
    end
  end

  always_comb begin
    station_d = station_q;
    rd_word   = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (ptr_q == PTR_W'(2 * w)) begin
        rd_word = station_q[16*w +: 16];
        if (data_wr && !mode_q.en) station_d[16*w +: 16] = cfg_wdata[15:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      ptr_q     <= '0;
      station_q <= '0;
    end else begin
      if (ctrl_wr) begin
        mode_q <= mode_d;
        ptr_q  <= ptr_d;
      end
      if (data_wr) station_q <= station_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_sel) begin
      cfg_rdata[15:0] = rd_word;
    end else begin
      cfg_rdata[CFG_W-1:MODE_LSB] = mode_q;
      cfg_rdata[PTR_W-1:0]        = ptr_q;
    end
  end

  assign mode    = mode_q;
  assign station = station_q;

  // R4
  addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && mode_q.en) |=> $stable(station_q));

  // R4
  flags_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && mode_q.en) |=>
      $stable({mode_q.acc_bc, mode_q.acc_mc, mode_q.acc_uc, mode_q.acc_pm}));

endmodule

// File: rtl/rxf_dest_capture.sv
module rxf_dest_capture #(
  parameter int MAC_BYTES = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_data,
  input  logic                   rx_last,
  output logic [8*MAC_BYTES-1:0] dest,
  output logic                   dest_done,
  output logic                   short_end
);

  localparam int CNT_W  = $clog2(MAC_BYTES + 1);
  localparam int HELD_W = 8 * (MAC_BYTES - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [HELD_W-1:0] held;

  always_comb begin
    cnt_d = cnt_q;
    if (rx_valid) begin
      if (rx_last)                             cnt_d = '0;
      else if (cnt_q < CNT_W'(MAC_BYTES))      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (rx_valid) cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < MAC_BYTES - 1; i++) begin : g_byte
    logic [7:0] byte_q;
    logic       ld;
    assign ld = rx_valid && (cnt_q == CNT_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  byte_q <= '0;
      else if (ld) byte_q <= rx_data;
    end
    assign held[8*i +: 8] = byte_q;
  end

  assign dest      = {rx_data, held};
  assign dest_done = rx_valid && (cnt_q == CNT_W'(MAC_BYTES - 1));
  assign short_end = rx_valid && rx_last && (cnt_q < CNT_W'(MAC_BYTES - 1));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(cnt_q) && $stable(held));

  // R5
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dest_done && short_end));

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int MAC_BYTES = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  filt_mode_t             mode,
  input  logic [8*MAC_BYTES-1:0] station,
  input  logic [8*MAC_BYTES-1:0] dest,
  input  logic                   dest_done,
  input  logic                   short_end,
  output logic                   dec_valid,
  output logic                   dec_accept,
  output logic [1:0]             dec_class
);

  logic       is_bc, is_mc, is_uc, is_match;
  logic       acc_d, acc_q, vld_q, load;
  dst_class_e cls_d, cls_q;

  assign is_bc    = &dest;
  assign is_mc    = dest[0] && !is_bc;
  assign is_uc    = !dest[0];
  assign is_match = (dest == station);

  always_comb begin
    if (is_bc)         cls_d = CLS_BCAST;
    else if (is_mc)    cls_d = CLS_MCAST;
    else if (is_match) cls_d = CLS_STATION;
    else               cls_d = CLS_OTHER;

    acc_d = mode.en && ((is_bc && mode.acc_bc) || (is_mc && mode.acc_mc) ||
                        (is_uc && mode.acc_uc) || (is_match && mode.acc_pm));
    if (short_end) begin
      cls_d = CLS_OTHER;
      acc_d = 1'b0;
    end
  end

  assign load = dest_done || short_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      acc_q <= 1'b0;
      cls_q <= CLS_OTHER;
    end else begin
      vld_q <= load;
      if (load) begin
        acc_q <= acc_d;
        cls_q <= cls_d;
      end else begin
        acc_q <= 1'b0;
        cls_q <= CLS_OTHER;
      end
    end
  end

  assign dec_valid  = vld_q;
  assign dec_accept = acc_q;
  assign dec_class  = cls_q;

  // R8
  off_rejects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !mode.en) |=> (dec_valid && !dec_accept));

  // R9
  short_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_end |=> (dec_valid && !dec_accept && dec_class == 2'b00));

  // R5
  accept_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> dec_valid);

  // R6
  bcast_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dest_done && (&dest)) |=> (dec_class == 2'b11));

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int MAC_BYTES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  output logic             dec_valid,
  output logic             dec_accept,
  output logic [1:0]       dec_class
);

  localparam int ADDR_W = 8 * MAC_BYTES;

  filt_mode_t        mode;
  logic [ADDR_W-1:0] station;
  logic [ADDR_W-1:0] dest;
  logic              dest_done, short_end;

  rxf_cfg_regs #(.MAC_BYTES(MAC_BYTES)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .mode      (mode),
    .station   (station)
  );

  rxf_dest_capture #(.MAC_BYTES(MAC_BYTES)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_last   (rx_last),
    .dest      (dest),
    .dest_done (dest_done),
    .short_end (short_end)
  );

  rxf_decide #(.MAC_BYTES(MAC_BYTES)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .station    (station),
    .dest       (dest),
    .dest_done  (dest_done),
    .short_end  (short_end),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .dec_class  (dec_class)
  );

endmodule

// File: tb/rx_dest_filter_test.sv
module rx_dest_filter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_last = 1'b0;
  logic        dec_valid, dec_accept;
  logic [1:0]  dec_class;

  int checks = 0;
  int errors = 0;

  logic [7:0] fb [16];
  int ndec, d_idx;
  logic d_acc;
  logic [1:0] d_cls;

  rx_dest_filter uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_last(rx_last), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dec_class(dec_class)
  );

  always #5 clk = ~clk;

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    @(negedge clk);
    cfg_sel = sel;
    #1 d = cfg_rdata;
  endtask

  task automatic observe(input int idx);
    if (dec_valid) begin
      ndec++;
      d_idx = idx;
      d_acc = dec_accept;
      d_cls = dec_class;
    end
  endtask

  task automatic set_addr(input logic [7:0] b0, b1, b2, b3, b4, b5);
    fb[0] = b0; fb[1] = b1; fb[2] = b2; fb[3] = b3; fb[4] = b4; fb[5] = b5;
    for (int i = 6; i < 16; i++) fb[i] = 8'(i * 17);
  endtask

  task automatic send(input int len, input bit gap);
    ndec = 0; d_idx = -1; d_acc = 1'b0; d_cls = 2'b00;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      observe(i - 1);
      rx_valid = 1'b1; rx_data = fb[i]; rx_last = (i == len - 1);
      if (gap) begin
        @(negedge clk);
        observe(i);
        rx_valid = 1'b0; rx_last = 1'b0;
      end
    end
    @(negedge clk);
    observe(len - 1);
    rx_valid = 1'b0; rx_last = 1'b0;
    @(negedge clk);
    observe(len - 1);
  endtask

  task automatic expect_dec(input string req, input int idx, input logic acc, input logic [1:0] cls);
    chk({req, " decision count"}, ndec, 1);
    chk({req, " decision cycle"}, d_idx, idx);
    chk({req, " accept"}, {31'b0, d_acc}, {31'b0, acc});
    chk({req, " class"}, {30'b0, d_cls}, {30'b0, cls});
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 dec_valid", {31'b0, dec_valid}, 0);
    chk("R1 dec_accept", {31'b0, dec_accept}, 0);
    rd(1'b0, v); chk("R1 ctrl read", v, 32'h0);
    for (int o = 0; o < 6; o += 2) begin
      wr(1'b0, o); rd(1'b1, v); chk("R1 word read", v, 32'h0);
    end
  endtask

  task automatic t_program;
    logic [31:0] v;
    wr(1'b0, 32'd0); wr(1'b1, 32'hFFFF_1102);
    wr(1'b0, 32'd2); wr(1'b1, 32'h0000_3322);
    wr(1'b0, 32'd4); wr(1'b1, 32'h0000_5544);
    wr(1'b0, 32'd6); wr(1'b1, 32'h0000_DEAD);
    rd(1'b1, v); chk("R3 odd offset reads zero", v, 32'h0);
    wr(1'b0, 32'd0); rd(1'b1, v); chk("R3 word0", v, 32'h1102);
    wr(1'b0, 32'd2); rd(1'b1, v); chk("R3 word1", v, 32'h3322);
    wr(1'b0, 32'd4); rd(1'b1, v); chk("R3 word2", v, 32'h5544);
    wr(1'b0, 32'h8800_0000);
    rd(1'b0, v); chk("R2 ctrl bits", v, 32'h8800_0000);
  endtask

  task automatic t_frozen;
    logic [31:0] v;
    wr(1'b0, 32'hF800_0002);
    rd(1'b0, v); chk("R4 flags held while enabled", v, 32'h8800_0002);
    wr(1'b1, 32'h0000_BEEF);
    rd(1'b1, v); chk("R4 word held while enabled", v, 32'h3322);
    wr(1'b0, 32'h0000_0000);
    rd(1'b0, v); chk("R2 enable cleared", v, 32'h0800_0000);
    wr(1'b0, 32'h8800_0000);
  endtask

  task automatic t_frames;
    set_addr(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
    send(10, 1'b0); expect_dec("R5 R7 station match", 5, 1'b1, 2'b01);
    send(6, 1'b0);  expect_dec("R5 six-byte frame", 5, 1'b1, 2'b01);
    send(10, 1'b1); expect_dec("R10 gapped frame", 5, 1'b1, 2'b01);
    set_addr(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h56);
    send(9, 1'b0);  expect_dec("R6 R7 other unicast", 5, 1'b0, 2'b00);
    set_addr(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    send(8, 1'b0);  expect_dec("R7 broadcast not enabled", 5, 1'b0, 2'b11);
    set_addr(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01);
    send(8, 1'b0);  expect_dec("R6 R7 multicast not enabled", 5, 1'b0, 2'b10);
  endtask

  task automatic t_modes;
    wr(1'b0, 32'h0);
    wr(1'b0, 32'hF000_0000);
    set_addr(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    send(8, 1'b0);  expect_dec("R7 broadcast accepted", 5, 1'b1, 2'b11);
    set_addr(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01);
    send(8, 1'b0);  expect_dec("R7 multicast accepted", 5, 1'b1, 2'b10);
    set_addr(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h56);
    send(8, 1'b0);  expect_dec("R7 any unicast accepted", 5, 1'b1, 2'b00);
  endtask

  task automatic t_disabled;
    wr(1'b0, 32'h7800_0000);
    set_addr(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
    send(8, 1'b0);  expect_dec("R8 disabled station", 5, 1'b0, 2'b01);
    set_addr(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    send(8, 1'b0);  expect_dec("R8 disabled broadcast", 5, 1'b0, 2'b11);
  endtask

  task automatic t_short;
    wr(1'b0, 32'hF800_0000);
    set_addr(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
    send(4, 1'b0);  expect_dec("R9 four-byte frame", 3, 1'b0, 2'b00);
    set_addr(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    send(1, 1'b0);  expect_dec("R9 one-byte frame", 0, 1'b0, 2'b00);
    set_addr(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
    send(7, 1'b0);  expect_dec("R5 frame after short one", 5, 1'b1, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_program;
    t_frozen;
    t_frames;
    t_modes;
    t_disabled;
    t_short;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule